// File: doc/BRIEF.md
# Layered State-Access Permission Registers

This block keeps the permission registers that decide which pieces of architectural state a less-privileged mode of a RISC-V hart may touch. There are three tiers of four 64-bit registers: a machine tier, a hypervisor tier and a supervisor tier. The most significant bit of a register in a higher tier unlocks the register with the same index in the tier below it. The block takes one CSR request per cycle. Each request carries an address, the current privilege and the virtualization flag. One cycle later the block answers with read data or with exactly one of two exception flags: illegal instruction or virtual instruction.

The block also drives four 64-bit permission vectors taken from register 0 of each tier. Each vector is the AND of the matching bits along the chain of tiers down to one less-privileged mode. The rest of the hart uses these vectors to gate access to the features they name. A parameter removes the extension, and then every access faults. A second parameter selects a 32-bit hart, where the upper halves of the machine and hypervisor registers get their own addresses.

Top module: `stateen_ctrl`

## Requirements
- R1: After reset all twelve registers are zero, all four permission vectors are zero and no response is pending.
- R2: A request taken at a clock edge is answered at the next edge. `rsp_valid` is high for exactly one cycle per request. An exception flag is raised only together with `rsp_valid`, and never both flags at once.
- R3: The machine tier answers at 0x30C-0x30F, the hypervisor tier at 0x60C-0x60F and the supervisor tier at 0x10C-0x10F, and the low two address bits give the index. When XLEN is 32, the upper halves of the machine and hypervisor registers answer at 0x31C-0x31F and 0x61C-0x61F. Any other address, including those upper-half addresses when XLEN is 64, raises illegal instruction.
- R4: When the PRESENT parameter is 0, every access raises illegal instruction.
- R5: An access to hypervisor or supervisor register n raises illegal instruction when bit 63 of machine register n is 0. This check comes before all others.
- R6: An access to supervisor register n while virtualized (`req_virt`=1 and privilege not machine) raises virtual instruction when bit 63 of hypervisor register n is 0.
- R7: Privilege is encoded as 0 = user, 1 = supervisor, 3 = machine. Machine registers need privilege 3, otherwise the access raises illegal instruction. Hypervisor registers raise virtual instruction when virtualized and illegal instruction from user mode. Supervisor registers raise illegal instruction from user mode and virtual instruction from virtual user mode.
- R8: Register 0 of the machine and hypervisor tiers implements bits 63, 62, 60, 59, 58, 57, 1 and 0. Registers 1-3 of those tiers implement only bit 63. Supervisor register 0 implements only bits 1 and 0, and supervisor registers 1-3 implement no bits. Unimplemented bits read as 0.
- R9: A bit of a hypervisor register whose machine counterpart is 0 reads as 0 and ignores writes. For a supervisor register the gate is the machine bit, ANDed with the hypervisor bit while virtualized. A gated bit keeps its stored value, which reads back once the gate opens.
- R10: A read returns the current value, gated as in R9. A write returns the value from before the write and stores the new value in the same edge.
- R11: A faulting access changes no register and returns zero read data.
- R12: `perm_hs` is machine register 0. `perm_vs` is machine AND hypervisor register 0. `perm_u` is machine AND supervisor register 0. `perm_vu` is the AND of all three register 0 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | CSR address |
| req_wdata | input | XLEN | Write data |
| req_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| req_virt | input | 1 | Hart is running virtualized |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | XLEN | Read data (old value on a write) |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_vfault | output | 1 | Virtual-instruction exception |
| perm_hs | output | 64 | Feature permissions for supervisor / hypervisor-supervisor mode |
| perm_vs | output | 64 | Feature permissions for virtual supervisor mode |
| perm_u | output | 64 | Feature permissions for user mode |
| perm_vu | output | 64 | Feature permissions for virtual user mode |

## Verification
A corrupted enable bit shows up on the very next response to a lower-tier access at that index. The fault flag flips between none, illegal and virtual, so an error in one gating stage points to one index and one tier. A stored value that leaks past its gate shows on the next read of that register, and at once on the permission vectors, which follow the registers in the same cycle. A faulting access that still writes is caught by a read-back of the register it targeted.

// File: rtl/stateen_pkg.sv
package stateen_pkg;

    localparam int NREG = 4;

    typedef enum logic [1:0] {
        TIER_M    = 2'd0,
        TIER_H    = 2'd1,
        TIER_S    = 2'd2,
        TIER_NONE = 2'd3
    } tier_e;

    localparam logic [7:0] PAGE_M_LO = 8'h30;
    localparam logic [7:0] PAGE_M_HI = 8'h31;
    localparam logic [7:0] PAGE_H_LO = 8'h60;
    localparam logic [7:0] PAGE_H_HI = 8'h61;
    localparam logic [7:0] PAGE_S    = 8'h10;

    localparam logic [63:0] GATE_BIT  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] REG0_FEAT = 64'h5E00_0000_0000_0003;
    localparam logic [63:0] SUP_KEEP  = 64'h0000_0000_FFFF_FFFF;

    function automatic logic [63:0] impl_mask(input logic [1:0] idx);
        return (idx == 2'd0) ? (GATE_BIT | REG0_FEAT) : GATE_BIT;
    endfunction

endpackage

// File: rtl/stateen_decode.sv
module stateen_decode
    import stateen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [11:0] addr,
    output logic        hit,
    output tier_e       tier,
    output logic [1:0]  idx,
    output logic        upper
);
    localparam bit HAS_HALVES = (XLEN == 32);

    always_comb begin
        hit   = 1'b0;
        tier  = TIER_NONE;
        idx   = addr[1:0];
        upper = addr[4];
        if (addr[3:2] == 2'b11) begin
            case (addr[11:4])
                PAGE_M_LO: begin hit = 1'b1;       tier = TIER_M; end
                PAGE_H_LO: begin hit = 1'b1;       tier = TIER_H; end
                PAGE_S:    begin hit = 1'b1;       tier = TIER_S; end
                PAGE_M_HI: begin hit = HAS_HALVES; tier = HAS_HALVES ? TIER_M : TIER_NONE; end
                PAGE_H_HI: begin hit = HAS_HALVES; tier = HAS_HALVES ? TIER_H : TIER_NONE; end
                default:   begin hit = 1'b0;       tier = TIER_NONE; end
            endcase
        end
    end
endmodule

// File: rtl/stateen_access.sv
module stateen_access
    import stateen_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic       hit,
    input  tier_e      tier,
    input  logic [1:0] priv,
    input  logic       virt_eff,
    input  logic       m_gate,
    input  logic       h_gate,
    output logic       illegal,
    output logic       vfault
);
    always_comb begin
        illegal = 1'b0;
        vfault  = 1'b0;
        if (!PRESENT || !hit) begin
            illegal = 1'b1;
        end else begin
            case (tier)
                TIER_M: illegal = (priv != 2'b11);
                TIER_H: begin
                    if (!m_gate)        illegal = 1'b1;
                    else if (virt_eff)  vfault  = 1'b1;
                    else if (priv == 2'b00) illegal = 1'b1;
                end
                TIER_S: begin
                    if (!m_gate)                 illegal = 1'b1;
                    else if (virt_eff && !h_gate) vfault = 1'b1;
                    else if (priv == 2'b00) begin
                        if (virt_eff) vfault  = 1'b1;
                        else          illegal = 1'b1;
                    end
                end
                default: illegal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/stateen_ctrl.sv
module stateen_ctrl
    import stateen_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit PRESENT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [11:0]     req_addr,
    input  logic [XLEN-1:0] req_wdata,
    input  logic [1:0]      req_priv,
    input  logic            req_virt,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_rdata,
    output logic            rsp_illegal,
    output logic            rsp_vfault,
    output logic [63:0]     perm_hs,
    output logic [63:0]     perm_vs,
    output logic [63:0]     perm_u,
    output logic [63:0]     perm_vu
);
    localparam logic [5:0] HALF_SHIFT = 6'd32;

    typedef struct packed {
        logic [NREG-1:0][63:0] m;
        logic [NREG-1:0][63:0] h;
        logic [NREG-1:0][63:0] s;
        logic                  vld;
        logic                  ill;
        logic                  vf;
        logic [XLEN-1:0]       rd;
    } state_t;

    state_t st_d, st_q;

    logic       dec_hit, dec_upper;
    tier_e      dec_tier;
    logic [1:0] dec_idx;
    logic       virt_eff;
    logic       acc_ill, acc_vf;
    logic [63:0] m_sel, h_sel, s_sel;

    assign virt_eff = req_virt && (req_priv != 2'b11);
    assign m_sel    = st_q.m[dec_idx];
    assign h_sel    = st_q.h[dec_idx];
    assign s_sel    = st_q.s[dec_idx];

    stateen_decode #(.XLEN(XLEN)) u_decode (
        .addr  (req_addr),
        .hit   (dec_hit),
        .tier  (dec_tier),
        .idx   (dec_idx),
        .upper (dec_upper)
    );

    stateen_access #(.PRESENT(PRESENT)) u_access (
        .hit      (dec_hit),
        .tier     (dec_tier),
        .priv     (req_priv),
        .virt_eff (virt_eff),
        .m_gate   (m_sel[63]),
        .h_gate   (h_sel[63]),
        .illegal  (acc_ill),
        .vfault   (acc_vf)
    );

    logic [63:0] live_mask, live_val, half_mask, wd_wide, merged, shifted;
    logic [5:0]  shamt;

    always_comb begin
        st_d = st_q;

        case (dec_tier)
            TIER_M:  begin live_mask = impl_mask(dec_idx);          live_val = m_sel; end
            TIER_H:  begin live_mask = impl_mask(dec_idx) & m_sel;  live_val = h_sel; end
            TIER_S:  begin
                live_mask = impl_mask(dec_idx) & SUP_KEEP & m_sel & (virt_eff ? h_sel : '1);
                live_val  = s_sel;
            end
            default: begin live_mask = '0; live_val = '0; end
        endcase

        shamt     = (XLEN == 32 && dec_upper) ? HALF_SHIFT : 6'd0;
        half_mask = (XLEN == 32) ? ({32'h0, 32'hFFFF_FFFF} << shamt) : '1;
        wd_wide   = 64'(req_wdata) << shamt;
        shifted   = (live_val & live_mask) >> shamt;
        merged    = (live_val & ~(live_mask & half_mask)) | (wd_wide & live_mask & half_mask);

        st_d.vld = req_valid;
        st_d.ill = req_valid && acc_ill;
        st_d.vf  = req_valid && acc_vf;
        st_d.rd  = (req_valid && !acc_ill && !acc_vf) ? shifted[XLEN-1:0] : '0;

        if (req_valid && req_write && !acc_ill && !acc_vf) begin
            case (dec_tier)
                TIER_M:  st_d.m[dec_idx] = merged;
                TIER_H:  st_d.h[dec_idx] = merged;
                TIER_S:  st_d.s[dec_idx] = merged;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid   = st_q.vld;
    assign rsp_illegal = st_q.ill;
    assign rsp_vfault  = st_q.vf;
    assign rsp_rdata   = st_q.rd;

    assign perm_hs = st_q.m[0];
    assign perm_vs = st_q.m[0] & st_q.h[0];
    assign perm_u  = st_q.m[0] & st_q.s[0];
    assign perm_vu = st_q.m[0] & st_q.h[0] & st_q.s[0];

    logic [NREG-1:0][63:0] m_all, h_all, s_all;
    assign m_all = st_q.m;
    assign h_all = st_q.h;
    assign s_all = st_q.s;

endmodule

// File: rtl/stateen_ctrl_chk.sv
module stateen_ctrl_chk #(
    parameter bit PRESENT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [11:0]       req_addr,
    input logic              rsp_valid,
    input logic              rsp_illegal,
    input logic              rsp_vfault,
    input logic [63:0]       perm_hs,
    input logic [63:0]       perm_vs,
    input logic [63:0]       perm_u,
    input logic [63:0]       perm_vu,
    input logic [3:0][63:0]  m_all,
    input logic [3:0][63:0]  h_all,
    input logic [3:0][63:0]  s_all
);
    assert_single_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_illegal || rsp_vfault) |-> (rsp_valid && !(rsp_illegal && rsp_vfault)));

    assert_resp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_absent_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!PRESENT && rsp_valid) |-> rsp_illegal);

    assert_machine_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:4] == 8'h60 && req_addr[3:2] == 2'b11
         && !m_all[req_addr[1:0]][63]) |=> rsp_illegal);

    assert_fault_keeps_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_illegal || rsp_vfault) |-> ($stable(m_all) && $stable(h_all) && $stable(s_all)));

    assert_perm_chain_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((perm_vs & ~perm_hs) == 64'd0) && ((perm_u & ~perm_hs) == 64'd0)
        && ((perm_vu & ~perm_vs) == 64'd0) && ((perm_vu & ~perm_u) == 64'd0));
endmodule

bind stateen_ctrl stateen_ctrl_chk #(.PRESENT(PRESENT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_illegal (rsp_illegal),
    .rsp_vfault  (rsp_vfault),
    .perm_hs     (perm_hs),
    .perm_vs     (perm_vs),
    .perm_u      (perm_u),
    .perm_vu     (perm_vu),
    .m_all       (m_all),
    .h_all       (h_all),
    .s_all       (s_all)
);

// File: tb/stateen_ctrl_bench.sv
`timescale 1ns/1ps
module stateen_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_virt = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_priv = 2'b11;

    logic        rsp_valid, rsp_illegal, rsp_vfault;
    logic [63:0] rsp_rdata, perm_hs, perm_vs, perm_u, perm_vu;
    logic        off_valid, off_illegal, off_vfault;
    logic [63:0] off_rdata, off_hs, off_vs, off_u, off_vu;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    stateen_ctrl #(.XLEN(64), .PRESENT(1'b1)) u_stateen_ctrl (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_priv, .req_virt,
        .rsp_valid, .rsp_rdata, .rsp_illegal, .rsp_vfault,
        .perm_hs, .perm_vs, .perm_u, .perm_vu
    );

    stateen_ctrl #(.XLEN(64), .PRESENT(1'b0)) u_stateen_ctrl_off (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_priv, .req_virt,
        .rsp_valid(off_valid), .rsp_rdata(off_rdata), .rsp_illegal(off_illegal),
        .rsp_vfault(off_vfault), .perm_hs(off_hs), .perm_vs(off_vs), .perm_u(off_u), .perm_vu(off_vu)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [63:0] wd;
        logic [1:0]  priv;
        logic        virt;
        logic        ill;
        logic        vf;
        logic [63:0] rd;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] FULL0 = 64'hDE00_0000_0000_0003;
    localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

    localparam int NVEC = 36;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h30C, 64'd0, 2'd3, 1'b0, 1'b0, 1'b0, 64'd0, 4'd1},   // R1 reset value
        '{1'b0, 12'h60C, 64'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'd0, 4'd5},   // R5 locked
        '{1'b0, 12'h10C, 64'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'd0, 4'd5},   // R5 locked
        '{1'b1, 12'h30C, ONES,  2'd3, 1'b0, 1'b0, 1'b0, 64'd0, 4'd10},  // R10 old value
        '{1'b0, 12'h30C, 64'd0, 2'd3, 1'b0, 1'b0, 1'b0, FULL0, 4'd8},   // R8 reg0 bits
        '{1'b1, 12'h30D, ONES,  2'd3, 1'b0, 1'b0, 1'b0, 64'd0, 4'd10},  // R10
        '{1'b0, 12'h30D, 64'd0, 2'd3, 1'b0, 1'b0, 1'b0, TOP,   4'd8},   // R8 reg1 bits
        '{1'b0, 12'h30C, 64'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'd0, 4'd7},   // R7 machine priv
        '{1'b1, 12'h60C, ONES,  2'd1, 1'b0, 1'b0, 1'b0, 64'd0, 4'd3},   // R3 hyp tier
        '{1'b0, 12'h60C, 64'd0, 2'd1, 1'b0, 1'b0, 1'b0, FULL0, 4'd9},   // R9 open gate
        '{1'b0, 12'h10C, 64'd0, 2'd1, 1'b1, 1'b0, 1'b0, 64'd0, 4'd6},   // R6 both open
        '{1'b1, 12'h10C, ONES,  2'd1, 1'b0, 1'b0, 1'b0, 64'd0, 4'd3},   // R3 sup tier
        '{1'b0, 12'h10C, 64'd0, 2'd1, 1'b0, 1'b0, 1'b0, 64'd3, 4'd8},   // R8 sup bits
        '{1'b0, 12'h10D, 64'd0, 2'd1, 1'b1, 1'b0, 1'b1, 64'd0, 4'd6},   // R6 hyp gate closed
        '{1'b0, 12'h10E, 64'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'd0, 4'd5},   // R5 idx 2
        '{1'b0, 12'h60D, 64'd0, 2'd1, 1'b1, 1'b0, 1'b1, 64'd0, 4'd7},   // R7 hyp from VS
        '{1'b0, 12'h60C, 64'd0, 2'd0, 1'b0, 1'b1, 1'b0, 64'd0, 4'd7},   // R7 hyp from U
        '{1'b0, 12'h10C, 64'd0, 2'd0, 1'b1, 1'b0, 1'b1, 64'd0, 4'd7},   // R7 sup from VU
        '{1'b0, 12'h31C, 64'd0, 2'd3, 1'b0, 1'b1, 1'b0, 64'd0, 4'd3},   // R3 no halves at 64
        '{1'b0, 12'h300, 64'd0, 2'd3, 1'b0, 1'b1, 1'b0, 64'd0, 4'd3},   // R3 unmapped
        '{1'b1, 12'h30C, 64'h5E00_0000_0000_0002, 2'd3, 1'b0, 1'b0, 1'b0, FULL0, 4'd10}, // R10
        '{1'b0, 12'h60C, 64'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'd0, 4'd5},   // R5 relocked
        '{1'b1, 12'h30C, ONES,  2'd3, 1'b0, 1'b0, 1'b0, 64'h5E00_0000_0000_0002, 4'd10}, // R10
        '{1'b1, 12'h60C, 64'd0, 2'd1, 1'b0, 1'b0, 1'b0, FULL0, 4'd9},   // R9 kept while locked
        '{1'b0, 12'h10C, 64'd0, 2'd1, 1'b1, 1'b0, 1'b1, 64'd0, 4'd6},   // R6
        '{1'b0, 12'h10C, 64'd0, 2'd1, 1'b0, 1'b0, 1'b0, 64'd3, 4'd6},   // R6 not virtual
        '{1'b1, 12'h30C, 64'd0, 2'd1, 1'b0, 1'b1, 1'b0, 64'd0, 4'd11},  // R11 faulting write
        '{1'b0, 12'h30C, 64'd0, 2'd3, 1'b0, 1'b0, 1'b0, FULL0, 4'd11},  // R11 unchanged
        '{1'b1, 12'h60E, ONES,  2'd1, 1'b0, 1'b1, 1'b0, 64'd0, 4'd11},  // R11 faulting write
        '{1'b1, 12'h30E, ONES,  2'd3, 1'b0, 1'b0, 1'b0, 64'd0, 4'd10},  // R10
        '{1'b0, 12'h60E, 64'd0, 2'd1, 1'b0, 1'b0, 1'b0, 64'd0, 4'd11},  // R11 unchanged
        '{1'b1, 12'h60C, 64'h4000_0000_0000_0002, 2'd1, 1'b0, 1'b0, 1'b0, 64'd0, 4'd9}, // R9
        '{1'b1, 12'h30C, 64'hC000_0000_0000_0001, 2'd3, 1'b0, 1'b0, 1'b0, FULL0, 4'd9}, // R9
        '{1'b0, 12'h60C, 64'd0, 2'd1, 1'b0, 1'b0, 1'b0, 64'h4000_0000_0000_0000, 4'd9}, // R9 gated read
        '{1'b0, 12'h10C, 64'd0, 2'd1, 1'b0, 1'b0, 1'b0, 64'd1, 4'd9},   // R9 sup gated
        '{1'b0, 12'h10C, 64'd0, 2'd1, 1'b1, 1'b0, 1'b1, 64'd0, 4'd6}    // R6 h0 bit63 cleared
    };

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [11:0] addr, input logic [63:0] wd,
                          input logic [1:0] priv, input logic virt);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_wdata = wd;   req_priv = priv; req_virt = virt;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!rsp_valid && !rsp_illegal && !rsp_vfault, "R1 idle", {63'd0, rsp_valid}, 64'd0);
        check((perm_hs | perm_vs | perm_u | perm_vu) == 64'd0, "R1 perms",
              perm_hs | perm_vs | perm_u | perm_vu, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            do_req(VECS[i].wr, VECS[i].addr, VECS[i].wd, VECS[i].priv, VECS[i].virt);
            checks++;
            if (!rsp_valid || rsp_illegal !== VECS[i].ill || rsp_vfault !== VECS[i].vf
                || rsp_rdata !== VECS[i].rd) begin
                failures++;
                $display("FAIL R%0d vec %0d actual v=%b ill=%b vf=%b rd=%h expected ill=%b vf=%b rd=%h",
                         VECS[i].req, i, rsp_valid, rsp_illegal, rsp_vfault, rsp_rdata,
                         VECS[i].ill, VECS[i].vf, VECS[i].rd);
            end
            if (i == 0) begin
                // R4: absent extension faults even from machine mode
                check(off_valid && off_illegal && !off_vfault, "R4 absent", {63'd0, off_illegal}, 64'd1);
            end
        end

        // R2: response lasts one cycle, flags drop with it
        do_req(1'b0, 12'h300, 64'd0, 2'd3, 1'b0);
        check(rsp_illegal, "R2 fault raised", {63'd0, rsp_illegal}, 64'd1);
        @(negedge clk);
        check(!rsp_valid && !rsp_illegal && !rsp_vfault, "R2 one cycle",
              {61'd0, rsp_valid, rsp_illegal, rsp_vfault}, 64'd0);

        // R12: permission vectors from final register-0 contents
        check(perm_hs == 64'hC000_0000_0000_0001, "R12 hs", perm_hs, 64'hC000_0000_0000_0001);
        check(perm_vs == 64'h4000_0000_0000_0000, "R12 vs", perm_vs, 64'h4000_0000_0000_0000);
        check(perm_u  == 64'd1, "R12 u", perm_u, 64'd1);
        check(perm_vu == 64'd0, "R12 vu", perm_vu, 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule